// File: doc/BRIEF.md
# Port Reset and Power-Down Controller

This block holds the per-port control bits for one line port and turns them into the control signals that the rest of the port uses. It combines three reset sources into one full-port reset: a software bit, an active-low hardware pin and a global software bit. It also produces a separate data-path-only reset, a clock enable for the port's clock-gating cells and an enable for the test-pattern generator. A one-cycle error-insert strobe is raised on the rising edge of a trigger that comes from either a local register bit or a global input.

Software writes the whole control word at once through `wr_en_i` and `wr_data_i`. The field positions are bit 0 full-port reset, bit 1 data-path reset, bit 2 power-down, bit 3 local error trigger, bit 4 trigger source select (1 selects the global input), and bit 5 pattern enable. The block also checks how long each reset bit was held. It counts the cycles for which each bit was high, and when a bit is released after fewer than `MIN_CYC` cycles it raises a one-cycle violation flag. `MIN_CYC` is the 100 ns minimum rounded up to whole clock periods, which is 13 at 8 ns.

Top module: `port_rstpd_ctl`

## Requirements
- R1: `port_rst_o` is high whenever the software reset bit (bit 0) is 1, `glb_rst_i` is 1 or `hw_rst_n` is 0, and low otherwise.
- R2: While `port_rst_o` is high, writes to bits 1 to 5 are ignored and those fields return to their defaults (bit 1 = 1, bit 2 = 1, others 0), one edge later. The software reset bit keeps its written value through a global reset.
- R3: `dp_rst_o` is high while bit 1 is set or `port_rst_o` is high. Bit 1 reads 1 after any reset, and writing 0 after release clears it.
- R4: `clk_en_o` is the inverse of the power-down bit (bit 2), which defaults to 1.
- R5: `pat_en_o` follows bit 5, which defaults to 0.
- R6: With bit 4 = 0, a 0-to-1 change of bit 3 gives `err_pulse_o` high for exactly one cycle, starting at the edge after the write. Holding the bit high or lowering it gives no pulse.
- R7: With bit 4 = 1, a rising `glb_err_i` sampled at an edge gives a one-cycle pulse right after that edge. The source that is not selected has no effect.
- R8: In the cycle after bit 4 changes value, no pulse is produced, even if the newly selected source is high.
- R9: If the software reset bit is released after N high cycles with 0 < N < 13, `viol_o[0]` is high for one cycle, starting one edge after the release. If N ≥ 13, it stays low.
- R10: The same rule applies to bit 1 on `viol_o[1]`.
- R11: No error pulse starts in the cycle after one in which `port_rst_o` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| hw_rst_n | input | 1 | Hardware reset pin, active low, synchronous |
| glb_rst_i | input | 1 | Global software reset |
| glb_err_i | input | 1 | Global error-insert trigger |
| wr_en_i | input | 1 | Control word write strobe |
| wr_data_i | input | 6 | Control word to write |
| port_rst_o | output | 1 | Effective full-port reset |
| dp_rst_o | output | 1 | Data-path reset |
| clk_en_o | output | 1 | Port clock enable (0 = powered down) |
| pat_en_o | output | 1 | Test-pattern enable |
| err_pulse_o | output | 1 | Single-cycle error-insert strobe |
| viol_o | output | 2 | Short-reset flags: bit 0 full reset, bit 1 data-path reset |

## Verification
A control field that is stuck, or that misses its default, shows on `clk_en_o`, `pat_en_o` or `dp_rst_o` in the first cycle after any reset ends. A stale edge-detector history shows as a missing or extra `err_pulse_o` one cycle after the trigger write or source switch. A high-time counter that is off by one shows only when the release falls at N = 12 or 13 cycles, so the hold-time sweep steps through every N from 1 to 16 and samples the flag in its single valid cycle.

// File: rtl/rstpd_pkg.sv
// Shared control-word layout for the port reset / power-down controller.
// Assumes the whole word is written at once.
package rstpd_pkg;
    localparam int CTRL_W = 6;

    // Field order is the bit order of the write word (bit 0 last).
    typedef struct packed {
        logic pat;   // bit 5: test pattern enable
        logic src;   // bit 4: error trigger source, 1 = global
        logic trig;  // bit 3: local error trigger
        logic pd;    // bit 2: power-down
        logic dp;    // bit 1: data-path reset
        logic rst;   // bit 0: full-port software reset
    } ctrl_t;
endpackage

// File: rtl/rstpd_ctrl_regs.sv
// Control word storage. The software reset bit clears only on the hardware
// pin. Every other field is forced to its default while the port reset is
// active, and writes to those fields are dropped in that time.
// Assumes port_rst already includes the hardware pin term.
module rstpd_ctrl_regs
    import rstpd_pkg::*;
(
    input  logic              clk,
    input  logic              hw_rst_n,
    input  logic              port_rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output ctrl_t             ctrl_q
);
    ctrl_t wr_word;
    assign wr_word = ctrl_t'(wr_data);

    // Software reset bit: survives every reset except the hardware pin.
    always_ff @(posedge clk) begin
        if (!hw_rst_n)
            ctrl_q.rst <= 1'b0;
        else if (wr_en)
            ctrl_q.rst <= wr_word.rst;
    end

    // Remaining fields: defaults during port reset, else written.
    always_ff @(posedge clk) begin
        if (!hw_rst_n || port_rst) begin
            ctrl_q.pat  <= 1'b0;
            ctrl_q.src  <= 1'b0;
            ctrl_q.trig <= 1'b0;
            ctrl_q.pd   <= 1'b1;
            ctrl_q.dp   <= 1'b1;
        end else if (wr_en) begin
            ctrl_q.pat  <= wr_word.pat;
            ctrl_q.src  <= wr_word.src;
            ctrl_q.trig <= wr_word.trig;
            ctrl_q.pd   <= wr_word.pd;
            ctrl_q.dp   <= wr_word.dp;
        end
    end
endmodule

// File: rtl/rstpd_width_mon.sv
// Minimum high-time monitor for one reset bit. It counts the cycles for
// which the level is high, saturating at MIN_CYC. When the level falls with
// a count below MIN_CYC, it gives a one-cycle flag on the next edge.
// Assumes the level is a register output in this clock domain.
module rstpd_width_mon #(
    parameter int MIN_CYC = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic viol
);
    localparam int CNT_W = $clog2(MIN_CYC + 1);
    localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_CYC);

    logic [CNT_W-1:0] cnt;

    // Count high cycles; judge the count in the first low cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            viol <= 1'b0;
        end else begin
            viol <= !level && (cnt != '0) && (cnt < MIN_V);
            if (!level)
                cnt <= '0;
            else if (cnt != MIN_V)
                cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rstpd_err_trig.sv
// Error-insert trigger. It selects the local or global trigger and gives a
// registered one-cycle pulse on a rising edge of the selected source. The
// pulse is suppressed in the cycle after the select changes and while the
// port reset is active. Assumes glb is synchronous to clk.
module rstpd_err_trig (
    input  logic clk,
    input  logic rst_n,
    input  logic port_rst,
    input  logic sel,
    input  logic loc,
    input  logic glb,
    output logic pulse
);
    logic src, src_prev, sel_prev;

    assign src = sel ? glb : loc;

    // Edge history plus the registered strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_prev <= 1'b0;
            sel_prev <= 1'b0;
            pulse    <= 1'b0;
        end else begin
            src_prev <= src;
            sel_prev <= sel;
            pulse    <= src && !src_prev && (sel == sel_prev) && !port_rst;
        end
    end
endmodule

// File: rtl/port_rstpd_ctl.sv
// Per-port reset and power-down controller. It merges the three reset sources,
// holds the control word, drives the port clock enable and pattern enable,
// checks reset hold times and generates the error-insert strobe.
// Assumes every input is synchronous to clk. hw_rst_n is used as a
// synchronous active-low reset.
module port_rstpd_ctl
    import rstpd_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 8000,
    parameter int MIN_HOLD_NS   = 100
) (
    input  logic              clk,
    input  logic              hw_rst_n,
    input  logic              glb_rst_i,
    input  logic              glb_err_i,
    input  logic              wr_en_i,
    input  logic [CTRL_W-1:0] wr_data_i,
    output logic              port_rst_o,
    output logic              dp_rst_o,
    output logic              clk_en_o,
    output logic              pat_en_o,
    output logic              err_pulse_o,
    output logic [1:0]        viol_o
);
    localparam int MIN_CYC = (MIN_HOLD_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam int N_MON   = 2;

    ctrl_t            ctrl_q;
    logic [N_MON-1:0] mon_level;

    // Effective full-port reset: any of the three sources.
    always_comb port_rst_o = ctrl_q.rst || !hw_rst_n || glb_rst_i;

    rstpd_ctrl_regs u_regs (
        .clk      (clk),
        .hw_rst_n (hw_rst_n),
        .port_rst (port_rst_o),
        .wr_en    (wr_en_i),
        .wr_data  (wr_data_i),
        .ctrl_q   (ctrl_q)
    );

    // Port-level control outputs.
    always_comb begin
        dp_rst_o = ctrl_q.dp || port_rst_o;
        clk_en_o = !ctrl_q.pd;
        pat_en_o = ctrl_q.pat;
    end

    assign mon_level = {ctrl_q.dp, ctrl_q.rst};

    for (genvar i = 0; i < N_MON; i++) begin : g_mon
        rstpd_width_mon #(.MIN_CYC(MIN_CYC)) u_mon (
            .clk   (clk),
            .rst_n (hw_rst_n),
            .level (mon_level[i]),
            .viol  (viol_o[i])
        );
    end

    rstpd_err_trig u_trig (
        .clk      (clk),
        .rst_n    (hw_rst_n),
        .port_rst (port_rst_o),
        .sel      (ctrl_q.src),
        .loc      (ctrl_q.trig),
        .glb      (glb_err_i),
        .pulse    (err_pulse_o)
    );
endmodule

// File: rtl/rstpd_checker.sv
// Port-level temporal checks for port_rstpd_ctl, bound to every instance.
module rstpd_checker (
    input logic       clk,
    input logic       hw_rst_n,
    input logic       glb_rst_i,
    input logic       port_rst_o,
    input logic       dp_rst_o,
    input logic       clk_en_o,
    input logic       pat_en_o,
    input logic       err_pulse_o,
    input logic [1:0] viol_o
);
    a_r1_glb_forces_port: assert property (@(posedge clk) disable iff (!hw_rst_n)
        glb_rst_i |-> port_rst_o);
    a_r3_dp_covers_port: assert property (@(posedge clk) disable iff (!hw_rst_n)
        port_rst_o |-> dp_rst_o);
    a_r4_pd_after_reset: assert property (@(posedge clk) disable iff (!hw_rst_n)
        port_rst_o |=> !clk_en_o);
    a_r5_pat_after_reset: assert property (@(posedge clk) disable iff (!hw_rst_n)
        port_rst_o |=> !pat_en_o);
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!hw_rst_n)
        err_pulse_o |=> !err_pulse_o);
    a_r9_viol_single: assert property (@(posedge clk) disable iff (!hw_rst_n)
        viol_o[0] |=> !viol_o[0]);
    a_r10_viol_single: assert property (@(posedge clk) disable iff (!hw_rst_n)
        viol_o[1] |=> !viol_o[1]);
    a_r11_quiet_in_reset: assert property (@(posedge clk) disable iff (!hw_rst_n)
        port_rst_o |=> !err_pulse_o);
endmodule

bind port_rstpd_ctl rstpd_checker u_chk (
    .clk         (clk),
    .hw_rst_n    (hw_rst_n),
    .glb_rst_i   (glb_rst_i),
    .port_rst_o  (port_rst_o),
    .dp_rst_o    (dp_rst_o),
    .clk_en_o    (clk_en_o),
    .pat_en_o    (pat_en_o),
    .err_pulse_o (err_pulse_o),
    .viol_o      (viol_o)
);

// File: tb/port_rstpd_ctl_test.sv
module port_rstpd_ctl_test;
    localparam int MIN = 13;
    localparam logic [5:0] B_RST = 6'h01, B_DP = 6'h02, B_TRIG = 6'h08,
                           B_SRC = 6'h10, B_PAT = 6'h20;

    logic clk = 1'b0;
    logic hw_rst_n = 1'b0, glb_rst_i = 1'b0, glb_err_i = 1'b0, wr_en_i = 1'b0;
    logic [5:0] wr_data_i = '0;
    logic port_rst_o, dp_rst_o, clk_en_o, pat_en_o, err_pulse_o;
    logic [1:0] viol_o;
    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    port_rstpd_ctl uut (
        .clk(clk), .hw_rst_n(hw_rst_n), .glb_rst_i(glb_rst_i), .glb_err_i(glb_err_i),
        .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .port_rst_o(port_rst_o),
        .dp_rst_o(dp_rst_o), .clk_en_o(clk_en_o), .pat_en_o(pat_en_o),
        .err_pulse_o(err_pulse_o), .viol_o(viol_o)
    );

    task automatic chk(string req, logic act, logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // One write through a single clock edge; returns at the following negedge.
    task automatic wr(logic [5:0] d);
        wr_data_i = d; wr_en_i = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic no_pulse(string req, int n);
        for (int i = 0; i < n; i++) begin
            chk(req, err_pulse_o, 1'b0);
            @(negedge clk);
        end
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        // Reset state (R1 R3 R4 R5)
        chk("R1 hw pin", port_rst_o, 1'b1);
        chk("R3 dp in reset", dp_rst_o, 1'b1);
        chk("R4 pd default", clk_en_o, 1'b0);
        chk("R5 pat default", pat_en_o, 1'b0);
        chk("R6 no pulse in reset", err_pulse_o, 1'b0);
        hw_rst_n = 1'b1;
        idle(20);
        chk("R1 released", port_rst_o, 1'b0);
        chk("R3 dp default 1", dp_rst_o, 1'b1);
        chk("R4 pd default 1", clk_en_o, 1'b0);
        wr(6'h00);
        chk("R3 dp cleared", dp_rst_o, 1'b0);
        chk("R4 pd cleared", clk_en_o, 1'b1);
        chk("R10 long hold no flag", viol_o[1], 1'b0);
        idle(1);
        chk("R10 long hold no flag later", viol_o[1], 1'b0);
        wr(B_PAT);
        chk("R5 pat set", pat_en_o, 1'b1);

        // R1 sweep over software and global bits
        for (int s = 0; s < 2; s++)
            for (int g = 0; g < 2; g++) begin
                glb_rst_i = g[0];
                wr(s[0] ? B_RST : 6'h00);
                chk("R1 or of sources", port_rst_o, s[0] | g[0]);
                glb_rst_i = 1'b0;
                wr(6'h00);
                idle(MIN + 2);
                wr(6'h00);
                chk("R1 cleared", port_rst_o, 1'b0);
            end

        // R2: defaults restored, writes ignored in reset
        wr(B_PAT);
        chk("R2 setup pat", pat_en_o, 1'b1);
        glb_rst_i = 1'b1;
        wr(B_PAT | B_SRC);
        glb_rst_i = 1'b0;
        idle(MIN + 2);
        chk("R2 pat back to default", pat_en_o, 1'b0);
        chk("R2 pd back to default", clk_en_o, 1'b0);
        chk("R2 dp back to default", dp_rst_o, 1'b1);
        wr(B_RST);
        glb_rst_i = 1'b1;
        idle(1);
        glb_rst_i = 1'b0;
        idle(1);
        chk("R2 sw bit kept", port_rst_o, 1'b1);
        idle(MIN);
        wr(6'h00);
        wr(6'h00);
        chk("R2 sw bit released", port_rst_o, 1'b0);
        chk("R3 dp write 0", dp_rst_o, 1'b0);
        idle(MIN + 2);

        // R9 hold-time sweep on the software reset bit
        for (int n = 1; n <= 16; n++) begin
            wr(B_RST);
            idle(n - 1);
            wr(6'h00);
            chk("R9 pre-flag", viol_o[0], 1'b0);
            idle(1);
            chk("R9 flag", viol_o[0], (n < MIN));
            idle(1);
            chk("R9 flag one cycle", viol_o[0], 1'b0);
            idle(MIN + 2);
            wr(6'h00);
            idle(2);
        end

        // R10 hold-time sweep on the data-path reset bit
        for (int n = 1; n <= 16; n++) begin
            wr(B_DP);
            chk("R3 dp bit set", dp_rst_o, 1'b1);
            idle(n - 1);
            wr(6'h00);
            idle(1);
            chk("R10 flag", viol_o[1], (n < MIN));
            chk("R10 other flag quiet", viol_o[0], 1'b0);
            idle(1);
            chk("R10 flag one cycle", viol_o[1], 1'b0);
        end

        // R6 local trigger
        wr(B_TRIG);
        chk("R6 not yet", err_pulse_o, 1'b0);
        idle(1);
        chk("R6 pulse", err_pulse_o, 1'b1);
        idle(1);
        no_pulse("R6 held high", 3);
        wr(6'h00);
        no_pulse("R6 falling", 2);
        wr(B_TRIG);
        idle(1);
        chk("R6 second pulse", err_pulse_o, 1'b1);
        idle(1);
        wr(6'h00);

        // R7 global ignored in local mode
        glb_err_i = 1'b1;
        no_pulse("R7 glb ignored", 3);
        // R8 switch to global while it is high
        wr(B_SRC);
        no_pulse("R8 switch suppressed", 3);
        glb_err_i = 1'b0;
        idle(1);
        glb_err_i = 1'b1;
        idle(1);
        chk("R7 glb pulse", err_pulse_o, 1'b1);
        idle(1);
        chk("R7 glb pulse ends", err_pulse_o, 1'b0);
        glb_err_i = 1'b0;
        idle(1);
        wr(B_SRC | B_TRIG);
        no_pulse("R7 local ignored", 3);
        wr(B_TRIG);
        no_pulse("R8 back to local suppressed", 3);
        wr(6'h00);

        // R11 no pulse while reset active
        wr(B_SRC);
        idle(2);
        glb_rst_i = 1'b1;
        glb_err_i = 1'b1;
        idle(1);
        no_pulse("R11 quiet in reset", 3);
        glb_rst_i = 1'b0;
        glb_err_i = 1'b0;
        idle(2);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule